// File: doc/BRIEF.md
# Bus-Oriented Universal Shift Register

An eight-bit storage register that can hold its value, shift one place in either direction, or capture a parallel word from a shared bidirectional data bus. Two select inputs choose the operation, which takes effect on the rising clock edge. Two active-low output controls decide whether the stored word is driven back onto the same bus.

Inside the chip the bus is split into a bus-in vector, a bus-out vector and a single drive-enable. An outer pad ring or tri-state stage combines these into real bidirectional lines.

Choosing parallel load always turns the drivers off, so an external source can own the lines during the capture edge. The two end bits of the register are brought out on their own serial outputs at all times. This lets several registers be chained into a longer shifter. An asynchronous active-low clear empties the register at once, whatever the clock, the selects or the output controls are doing.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is low, the stored word is 0 at once, without waiting for a clock edge. It stays 0 across clock edges in any mode, and this holds whether or not the bus is being driven.
- R2: With {`sel1`,`sel0`} = 2'b00 (hold), a clock edge leaves the stored word unchanged, and `bus_in` has no effect.
- R3: With {`sel1`,`sel0`} = 2'b11 (load), a clock edge copies `bus_in` into the stored word. This works with the output controls in any state.
- R4: While {`sel1`,`sel0`} = 2'b11, `bus_oe` is 0 regardless of `oe_a_n` and `oe_b_n`.
- R5: Outside load mode, `bus_oe` is 1 exactly when both `oe_a_n` and `oe_b_n` are 0. `bus_out` always shows the stored word.
- R6: With {`sel1`,`sel0`} = 2'b01 (shift right), a clock edge moves each bit i to bit i+1 and takes `ser_r_in` into bit 0.
- R7: With {`sel1`,`sel0`} = 2'b10 (shift left), a clock edge moves each bit i to bit i-1 and takes `ser_l_in` into bit 7.
- R8: `q_lsb` always equals stored bit 0 and `q_msb` always equals stored bit 7, whatever the value of `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| sel0 | input | 1 | Function select, low bit |
| sel1 | input | 1 | Function select, high bit |
| oe_a_n | input | 1 | Output control A, active low |
| oe_b_n | input | 1 | Output control B, active low |
| ser_r_in | input | 1 | Serial input entering bit 0 on a right shift |
| ser_l_in | input | 1 | Serial input entering bit 7 on a left shift |
| bus_in | input | 8 | Value currently on the shared bus |
| bus_out | output | 8 | Stored word offered to the bus |
| bus_oe | output | 1 | Bus drive enable |
| q_lsb | output | 1 | Stored bit 0 |
| q_msb | output | 1 | Stored bit 7 |

## Verification
Hold, shift and load each show their result on `bus_out`, `q_lsb` and `q_msb` one clock edge after the select value is applied, because a single register stage lies on every such path. `bus_oe` has no register stage and follows the selects and output controls within the same cycle. Clear also has no register stage and acts within the cycle in which it falls.

The bench changes inputs on the falling edge. It samples one nanosecond after the next rising edge, which checks the registered word and the combinational enable together. For clear, it samples in the middle of a cycle, before any clock edge could be responsible for the result.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the universal shift register.
// Assumes the select pair is packed as {sel1, sel0}.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
// Module: usr_ctrl
// Turns the select pair into a mode and computes the bus drive enable.
// Assumes both output controls are active low. The drivers are always off
// in load mode, so an external source can own the bus.
module usr_ctrl
    import usr_pkg::*;
(
    input  logic      sel0,
    input  logic      sel1,
    input  logic      oe_a_n,
    input  logic      oe_b_n,
    output usr_mode_e mode,
    output logic      drive_en
);
    // Purpose: decode the mode and gate the drivers.
    always_comb begin
        mode     = usr_mode_e'({sel1, sel0});
        drive_en = (mode != MODE_LOAD) && !oe_a_n && !oe_b_n;
    end
endmodule

// File: rtl/usr_core.sv
// Module: usr_core
// The storage bits together with the next-value selection for each bit.
// Assumes the clear is asynchronous and active low. Bit 0 takes the right
// serial input and bit WIDTH-1 takes the left serial input.
module usr_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  usr_mode_e        mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lo_edge
            assign from_lo = ser_r;
        end else begin : g_lo_mid
            assign from_lo = q[i-1];
        end
        if (i == MSB) begin : g_hi_edge
            assign from_hi = ser_l;
        end else begin : g_hi_mid
            assign from_hi = q[i+1];
        end
        assign nxt[i] = (mode == MODE_LOAD) ? par_in[i] :
                        (mode == MODE_SHR)  ? from_lo   :
                        (mode == MODE_SHL)  ? from_hi   : q[i];
    end

    // Purpose: store the next word; the clear takes priority over the clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/usr_shift_reg.sv
// Module: usr_shift_reg (top)
// An eight-bit universal shift register on a split bidirectional bus.
// Assumes a tri-state stage outside this block combines bus_out and bus_oe
// onto the pads. The serial taps are valid whether or not the bus is driven.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sel0,
    input  logic             sel1,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             q_lsb,
    output logic             q_msb
);
    usr_mode_e        mode;
    logic [WIDTH-1:0] q;

    usr_ctrl i_ctrl (
        .sel0     (sel0),
        .sel1     (sel1),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode     (mode),
        .drive_en (bus_oe)
    );

    usr_core #(.WIDTH(WIDTH)) i_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .mode   (mode),
        .ser_r  (ser_r_in),
        .ser_l  (ser_l_in),
        .par_in (bus_in),
        .q      (q)
    );

    // Purpose: expose the stored word and its two end taps.
    always_comb begin
        bus_out = q;
        q_lsb   = q[0];
        q_msb   = q[WIDTH-1];
    end
endmodule

// File: rtl/usr_shift_reg_chk.sv
// Module: usr_shift_reg_chk
// Watches the ports of usr_shift_reg and checks mode behaviour and bus
// gating over time. It is attached to the top module by the bind below.
module usr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             sel0,
    input logic             sel1,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_r_in,
    input logic             ser_l_in,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             q_lsb,
    input logic             q_msb
);
    AST_LOAD_NO_DRIVE: assert property (@(posedge clk) (sel0 && sel1) |-> !bus_oe); // R4
    AST_OE_GATE: assert property (@(posedge clk) (oe_a_n || oe_b_n) |-> !bus_oe); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (!sel1 && !sel0) |=> $stable(bus_out)); // R2
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        (sel1 && sel0) |=> (bus_out == $past(bus_in))); // R3
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!clr_n)
        (!sel1 && sel0) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_r_in)})); // R6
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!clr_n)
        (sel1 && !sel0) |=> (bus_out == {$past(ser_l_in), $past(bus_out[WIDTH-1:1])})); // R7
    AST_SERIAL_TAPS: assert property (@(posedge clk)
        (q_lsb == bus_out[0]) && (q_msb == bus_out[WIDTH-1])); // R8
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) i_usr_shift_reg_chk (.*);

// File: tb/test_usr_shift_reg.sv
// Bench for usr_shift_reg: a table of vectors walked by one loop, followed
// by directed tests for the clear. The clock runs at 125 MHz.
module test_usr_shift_reg;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       sel0 = 1'b0, sel1 = 1'b0;
    logic       oe_a_n = 1'b0, oe_b_n = 1'b0;
    logic       ser_r_in = 1'b0, ser_l_in = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe, q_lsb, q_msb;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usr_shift_reg i_usr_shift_reg (
        .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_r_in(ser_r_in), .ser_l_in(ser_l_in),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .q_lsb(q_lsb), .q_msb(q_msb)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       oa;
        logic       ob;
        logic       sr;
        logic       sl;
        logic [7:0] din;
        logic [7:0] exp_q;
        logic       exp_oe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0}, // R3 R4 load, outputs enabled
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1}, // R2 R5 hold, driving
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h4B, 1'b1}, // R6 serial 1 in
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h96, 1'b1}, // R6 serial 0 in
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b1}, // R7 serial 1 in
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h65, 1'b1}, // R7 serial 0 in
        '{2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}, // R3 load, outputs disabled
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h3C, 1'b0}, // R5 control A high
        '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h3C, 1'b0}, // R5 control B high
        '{2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'hC3, 1'b0}, // R3 R4 load, mixed controls
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hC3, 1'b1}, // R2 bus ignored in hold
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h86, 1'b1}  // R6 bus ignored in shift
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
        finish_run();
    end

    initial begin
        // R1: reset state while clear is held low.
        repeat (2) @(posedge clk);
        #1;
        check(bus_out == 8'h00, "R1", bus_out, 8'h00);
        check(bus_oe == 1'b1, "R5", {7'd0, bus_oe}, 8'h01);
        @(negedge clk);
        clr_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {sel1, sel0} = VECS[v].sel;
            oe_a_n = VECS[v].oa;
            oe_b_n = VECS[v].ob;
            ser_r_in = VECS[v].sr;
            ser_l_in = VECS[v].sl;
            bus_in = VECS[v].din;
            @(posedge clk);
            #1;
            check(bus_out == VECS[v].exp_q, "R2/R3/R6/R7 word", bus_out, VECS[v].exp_q);
            check(bus_oe == VECS[v].exp_oe, "R4/R5 drive", {7'd0, bus_oe}, {7'd0, VECS[v].exp_oe});
            check({q_msb, q_lsb} == {VECS[v].exp_q[7], VECS[v].exp_q[0]}, "R8 taps",
                  {6'd0, q_msb, q_lsb}, {6'd0, VECS[v].exp_q[7], VECS[v].exp_q[0]});
        end

        // R1: clear dropped in the middle of a shift, with the bus driven.
        @(negedge clk);
        {sel1, sel0} = 2'b11; bus_in = 8'hFF;
        @(negedge clk);
        {sel1, sel0} = 2'b01; ser_r_in = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        @(posedge clk);
        #2;
        clr_n = 1'b0;
        #1;
        check(bus_out == 8'h00, "R1 async", bus_out, 8'h00);
        check(q_lsb == 1'b0 && q_msb == 1'b0, "R8 taps after clear", {6'd0, q_msb, q_lsb}, 8'h00);
        @(posedge clk);
        #1;
        check(bus_out == 8'h00, "R1 priority over shift", bus_out, 8'h00);

        // R1: clear with outputs disabled during a load.
        @(negedge clk);
        {sel1, sel0} = 2'b11; oe_a_n = 1'b1; bus_in = 8'h5A;
        @(posedge clk);
        #1;
        check(bus_out == 8'h00, "R1 priority over load", bus_out, 8'h00);
        @(negedge clk);
        clr_n = 1'b1;
        {sel1, sel0} = 2'b00;
        @(posedge clk);
        #1;
        check(bus_out == 8'h00, "R1/R2 stays clear", bus_out, 8'h00);

        // R3: load after the clear is released.
        @(negedge clk);
        {sel1, sel0} = 2'b11;
        @(posedge clk);
        #1;
        check(bus_out == 8'h5A, "R3 load after clear", bus_out, 8'h5A);
        finish_run();
    end
endmodule